// File: doc/BRIEF.md
# Quasi-Bidirectional Port Expander with Change Interrupt

This block is a two-wire serial bus slave that owns an 8-bit quasi-bidirectional I/O port and an active-low change interrupt. Its 7-bit bus address is a constant 0 in the top position followed by six strap inputs. A master writes bytes to set the port latch. A pin whose latch holds 0 is pulled low. A pin whose latch holds 1 is only weakly pulled high, so an external device can pull it low and the master can read it as an input. No direction register is needed for this. A master read samples the pin levels, one sample per byte, and shifts them out.

Each pad is modelled as three enables: a low driver, a weak pull-up and a strong pull-up. The strong pull-up is a short boost that speeds a 0-to-1 output transition. The interrupt compares the synchronised pin levels against a reference. That reference is taken when the master accesses the port, and it also clears when the pins return to it. SCL and SDA are oversampled by the system clock and pass through a spike filter.

Top module: `qpx_expander`

## Requirements
- R1: The slave acknowledges only the address {0, strap[5:0]}, with bit 0 of the address byte selecting read (1) or write (0). Any other address gets a NACK (SDA left high), and the port is not changed.
- R2: After reset every latch bit is 1. That gives pin_drive_low = 0x00, pin_weak_pu = 0xFF, pin_strong_pu = 0x00, irq_n = 1 and sda_oe = 0.
- R3: In a write transaction, each data byte is loaded into the port latch at the SCL falling edge that opens its acknowledge bit. Consecutive bytes in one transaction each update the port.
- R4: A latch bit that goes from 0 to 1 asserts pin_strong_pu for that pin. It is released at the next SCL falling edge, and it is only ever set on a pin whose latch is 1.
- R5: pin_drive_low is the inverse of the latch, and pin_weak_pu equals the latch.
- R6: irq_n goes low when a pin whose latch is 1 differs from the reference. Pins whose latch is 0 never raise the interrupt.
- R7: In a read, the reference is loaded with the pin levels at the SCL rising edge of the address acknowledge and of every master acknowledge. This clears the interrupt.
- R8: In a write, the reference is loaded with the written byte when that byte is latched. This clears the interrupt if the pins match.
- R9: The interrupt clears when the pins return to the reference without any bus access.
- R10: Transactions to other addresses leave the interrupt and the reference unchanged.
- R11: A read returns the pin levels sampled for each byte, MSB first. The read continues while the master acknowledges and stops after a master NACK. After the STOP, sda_oe stays 0.
- R12: A pulse on SCL or SDA shorter than FILT_LEN system clocks is ignored. A 1-cycle SCL pulse while SCL is low, or a 1-cycle SDA dip while SCL is high, does not corrupt a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| strap | input | 6 | Hardware address straps (address bits 5..0) |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| pin_in | input | 8 | Pad levels of the port pins |
| pin_drive_low | output | 8 | Per-pin low driver enable |
| pin_weak_pu | output | 8 | Per-pin weak pull-up enable |
| pin_strong_pu | output | 8 | Per-pin momentary strong pull-up enable |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
Each bus line reaches the protocol engine through a 2-flop synchroniser and a FILT_LEN-cycle filter, plus one edge register. With the default FILT_LEN of 4, the engine sees an edge about 7 system cycles after the pin moves. The latch and the strong pull-up change one cycle after that. irq_n follows a pin change two cycles later, through the pin synchroniser. The bench keeps SCL half-periods at 16 cycles, so every result has settled long before the next edge. It samples SDA in the middle of the SCL-high phase, and it samples port and interrupt outputs 10 cycles after the bus edge or pin change that caused them. The strong pull-up is checked in the middle of the acknowledge high phase and again 10 cycles after the falling edge that must release it.

// File: rtl/qpx_pkg.sv
// Shared types for the quasi-bidirectional port expander.
package qpx_pkg;
    localparam int BYTE_W = 8;
    localparam logic ADDR_TOP_BIT = 1'b0;

    // Protocol engine phase within a transaction.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } bus_state_t;
endpackage

// File: rtl/qpx_line_filter.sv
// Synchronises one bus line and rejects pulses shorter than FILT_LEN clocks.
// Assumes the line idles high; the filtered output resets to 1.
module qpx_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic s1, s2;
    logic [CW-1:0] cnt;

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= raw;
            s2 <= s1;
        end
    end

    // Accept a new level only after it has persisted FILT_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            cnt   <= '0;
        end else if (s2 == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_LEN - 1)) begin
            clean <= s2;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/qpx_bus_engine.sv
// Bus slave protocol engine: start/stop detection, address match, byte
// shifting and acknowledge handling. Works on filtered SCL/SDA levels.
// Emits a one-cycle write strobe with the received byte and a one-cycle
// read strobe at each point where the port is sampled for transmission.
module qpx_bus_engine
    import qpx_pkg::*;
#(
    parameter int STRAP_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl,
    input  logic               sda,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  pins,
    output logic               sda_oe,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               rd_stb,
    output logic               scl_fall,
    output logic               busy
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    bus_state_t        state;
    logic              scl_q, sda_q;
    logic              rw, mack;
    logic [CNT_W-1:0]  bcnt;
    logic [BYTE_W-1:0] sh, tx;
    logic              scl_rise, start_c, stop_c;

    // Previous filtered levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Decode bus events from current and previous levels.
    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        start_c  = scl & scl_q & sda_q & ~sda;
        stop_c   = scl & scl_q & ~sda_q & sda;
        busy     = (state != ST_IDLE);
    end

    // Transaction sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            rd_stb  <= 1'b0;
            wr_data <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            bcnt    <= '0;
            sh      <= '0;
            tx      <= '0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (start_c) begin
                state  <= ST_ADDR;
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh   <= {sh[BYTE_W-2:0], sda};
                            bcnt <= bcnt + 1'b1;
                        end else if (scl_fall && bcnt == CNT_W'(BYTE_W)) begin
                            if (sh[BYTE_W-1:1] == {ADDR_TOP_BIT, strap}) begin
                                sda_oe <= 1'b1;
                                rw     <= sh[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_rise && rw) begin
                            tx     <= pins;
                            rd_stb <= 1'b1;
                        end else if (scl_fall) begin
                            bcnt <= '0;
                            if (rw) begin
                                sda_oe <= ~tx[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            sh   <= {sh[BYTE_W-2:0], sda};
                            bcnt <= bcnt + 1'b1;
                        end else if (scl_fall && bcnt == CNT_W'(BYTE_W)) begin
                            sda_oe  <= 1'b1;
                            wr_stb  <= 1'b1;
                            wr_data <= sh;
                            state   <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bcnt   <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bcnt <= bcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bcnt == CNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[BYTE_W-2];
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda;
                            if (!sda) begin
                                tx     <= pins;
                                rd_stb <= 1'b1;
                            end
                        end else if (scl_fall) begin
                            if (mack) begin
                                sda_oe <= ~tx[BYTE_W-1];
                                bcnt   <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/qpx_port_core.sv
// Port latch, pad enables, strong pull-up pulse and change interrupt.
// Assumes wr_stb and rd_stb are one-cycle pulses and never coincide.
// A newly released pin is masked from the interrupt until its level has
// crossed the pin synchroniser.
module qpx_port_core #(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    input  logic              wr_stb,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              scl_fall,
    output logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] pin_drive_low,
    output logic [PORT_W-1:0] pin_weak_pu,
    output logic [PORT_W-1:0] pin_strong_pu,
    output logic              irq_n
);
    logic [PORT_W-1:0] sync_q [SYNC_STAGES];
    logic [PORT_W-1:0] hist_q [SYNC_STAGES];
    logic [PORT_W-1:0] latch_q, spu_q, ref_q, settled;

    // Pin synchroniser and latch history, both reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                sync_q[i] <= '1;
                hist_q[i] <= '1;
            end
        end else begin
            sync_q[0] <= pin_in;
            hist_q[0] <= latch_q;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
                hist_q[i] <= hist_q[i-1];
            end
        end
    end

    // Output latch and strong pull-up pulse, ended by an SCL falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
            spu_q   <= '0;
        end else if (wr_stb) begin
            latch_q <= wr_data;
            spu_q   <= ~latch_q & wr_data;
        end else if (scl_fall) begin
            spu_q <= '0;
        end
    end

    // Interrupt reference, reloaded on every port access.
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_q <= '1;
        else if (wr_stb) ref_q <= wr_data;
        else if (rd_stb) ref_q <= pin_sync;
    end

    // Pins count as inputs once the latch has been 1 through the synchroniser.
    always_comb begin
        settled = latch_q;
        for (int i = 0; i < SYNC_STAGES; i++) settled &= hist_q[i];
    end

    assign pin_sync      = sync_q[SYNC_STAGES-1];
    assign pin_drive_low = ~latch_q;
    assign pin_weak_pu   = latch_q;
    assign pin_strong_pu = spu_q;
    assign irq_n         = ~|((pin_sync ^ ref_q) & settled);
endmodule

// File: rtl/qpx_expander.sv
// Top of the quasi-bidirectional port expander: bus line filters, protocol
// engine and port core. SDA is open-drain: sda_oe = 1 pulls the line low.
module qpx_expander
    import qpx_pkg::*;
#(
    parameter int STRAP_W     = 6,
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [BYTE_W-1:0]  pin_in,
    output logic [BYTE_W-1:0]  pin_drive_low,
    output logic [BYTE_W-1:0]  pin_weak_pu,
    output logic [BYTE_W-1:0]  pin_strong_pu,
    output logic               irq_n
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw, line_clean;
    logic               wr_stb, rd_stb, scl_fall, bus_busy;
    logic [BYTE_W-1:0]  wr_data, pin_sync;

    assign line_raw = {sda_in, scl_in};

    // One spike filter per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        qpx_line_filter #(.FILT_LEN(FILT_LEN)) filt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (line_raw[g]),
            .clean (line_clean[g])
        );
    end

    qpx_bus_engine #(.STRAP_W(STRAP_W)) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (line_clean[0]),
        .sda      (line_clean[1]),
        .strap    (strap),
        .pins     (pin_sync),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb),
        .scl_fall (scl_fall),
        .busy     (bus_busy)
    );

    qpx_port_core #(.PORT_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) port_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .wr_stb        (wr_stb),
        .wr_data       (wr_data),
        .rd_stb        (rd_stb),
        .scl_fall      (scl_fall),
        .pin_sync      (pin_sync),
        .pin_drive_low (pin_drive_low),
        .pin_weak_pu   (pin_weak_pu),
        .pin_strong_pu (pin_strong_pu),
        .irq_n         (irq_n)
    );
endmodule

// File: rtl/qpx_expander_chk.sv
// Protocol and port properties for qpx_expander, attached by bind.
module qpx_expander_chk #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_fall,
    input logic              wr_stb,
    input logic              busy,
    input logic [PORT_W-1:0] pin_weak_pu,
    input logic [PORT_W-1:0] pin_strong_pu
);
    // R1: the slave starts pulling SDA only just after an SCL falling edge.
    a_r1_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R11: SDA is never pulled outside a transaction.
    a_r11_oe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> busy);

    // R3: the port latch changes only right after a write strobe.
    a_r3_port_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_weak_pu) |-> $past(wr_stb));

    // R4: the strong pull-up is only ever on a pin whose latch is 1.
    a_r4_spu_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_strong_pu & ~pin_weak_pu) == '0);

    // R4: an SCL falling edge without a new write ends the strong pull-up.
    a_r4_spu_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_fall) && !$past(wr_stb)) |-> (pin_strong_pu == '0));
endmodule

bind qpx_expander qpx_expander_chk #(.PORT_W(8)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sda_oe        (sda_oe),
    .scl_fall      (scl_fall),
    .wr_stb        (wr_stb),
    .busy          (bus_busy),
    .pin_weak_pu   (pin_weak_pu),
    .pin_strong_pu (pin_strong_pu)
);

// File: tb/qpx_expander_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them as observations arrive from the bus and the pads.
module qpx_expander_tb_top;
    localparam int H = 16;
    localparam logic [5:0] STRAP = 6'b101101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] ext_low = 8'h00;
    logic       sda_oe, irq_n, sda_line;
    logic [7:0] pin_in, pin_drive_low, pin_weak_pu, pin_strong_pu;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    string       exp_tag_q[$];
    logic [31:0] exp_val_q[$];
    logic [31:0] act_val;
    event        obs_ev;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign pin_in   = ~(pin_drive_low | ext_low);

    qpx_expander dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap         (STRAP),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .sda_oe        (sda_oe),
        .pin_in        (pin_in),
        .pin_drive_low (pin_drive_low),
        .pin_weak_pu   (pin_weak_pu),
        .pin_strong_pu (pin_strong_pu),
        .irq_n         (irq_n)
    );

    // Monitor: pops the next expected item for each observation.
    initial begin
        forever begin
            @(obs_ev);
            checks++;
            if (exp_val_q.size() == 0) begin
                failures++;
                $display("FAIL unexpected observation act=%0h exp=none", act_val);
            end else begin
                string       t;
                logic [31:0] e;
                t = exp_tag_q.pop_front();
                e = exp_val_q.pop_front();
                if (act_val !== e) begin
                    failures++;
                    $display("FAIL %s act=%0h exp=%0h", t, act_val, e);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push the expectation, then publish the observation.
    task automatic expect_obs(input string tag, input logic [31:0] exp_v, input logic [31:0] act_v);
        exp_tag_q.push_back(tag);
        exp_val_q.push_back(exp_v);
        act_val = act_v;
        -> obs_ev;
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H/2);
        scl_m = 1'b1; wait_clk(H/2);
        sda_m = 1'b0; wait_clk(H/2);
        scl_m = 1'b0; wait_clk(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H/2);
        scl_m = 1'b1; wait_clk(H/2);
        sda_m = 1'b1; wait_clk(H);
    endtask

    // One bit with optional glitches: SCL pulse while low, SDA dip while high.
    task automatic put_bit(input logic b, input bit gscl, input bit gsda);
        wait_clk(H/2);
        sda_m = b;
        wait_clk(H/4);
        if (gscl) begin scl_m = 1'b1; wait_clk(1); scl_m = 1'b0; end
        wait_clk(H/4);
        scl_m = 1'b1;
        wait_clk(H/2);
        if (gsda) begin sda_m = 1'b0; wait_clk(1); sda_m = b; end
        wait_clk(H/2);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wait_clk(H/2);
        sda_m = 1'b1;
        wait_clk(H/2);
        scl_m = 1'b1;
        wait_clk(H/2);
        b = sda_line;
        wait_clk(H/2);
        scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i], 1'b0, 1'b0);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_bits(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
    endtask

    initial begin
        logic       ack, b;
        logic [7:0] v;
        const logic [7:0] MY_W  = {1'b0, STRAP, 1'b0};
        const logic [7:0] MY_R  = {1'b0, STRAP, 1'b1};

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // Reset state
        expect_obs("R2 drive_low", 32'h00, {24'h0, pin_drive_low});
        expect_obs("R2 weak_pu",   32'hFF, {24'h0, pin_weak_pu});
        expect_obs("R2 strong_pu", 32'h00, {24'h0, pin_strong_pu});
        expect_obs("R2 irq_n",     32'h1,  {31'h0, irq_n});
        expect_obs("R2 sda_oe",    32'h0,  {31'h0, sda_oe});

        // Wrong address (leading 1): NACK, port untouched
        bus_start();
        put_byte({1'b1, STRAP, 1'b0}, ack);
        expect_obs("R1 nack foreign addr", 32'h0, {31'h0, ack});
        put_byte(8'h00, ack);
        bus_stop();
        wait_clk(10);
        expect_obs("R1 port unchanged", 32'hFF, {24'h0, pin_weak_pu});

        // Two-byte write
        bus_start();
        put_byte(MY_W, ack);
        expect_obs("R1 ack own addr", 32'h1, {31'h0, ack});
        put_byte(8'h5A, ack);
        wait_clk(10);
        expect_obs("R3 first byte latched", 32'h5A, {24'h0, pin_weak_pu});
        expect_obs("R5 drive_low inverse",  32'hA5, {24'h0, pin_drive_low});
        for (int i = 7; i >= 0; i--) put_bit(v_of(8'h0F, i), 1'b0, 1'b0);
        wait_clk(H/2);
        sda_m = 1'b1;
        wait_clk(H/2);
        scl_m = 1'b1;
        wait_clk(H/2);
        expect_obs("R4 strong pulse on rising bits", 32'h05, {24'h0, pin_strong_pu});
        expect_obs("R3 second byte acked", 32'h0, {31'h0, sda_line});
        wait_clk(H/2);
        scl_m = 1'b0;
        wait_clk(10);
        expect_obs("R4 strong released at SCL fall", 32'h00, {24'h0, pin_strong_pu});
        expect_obs("R3 second byte latched", 32'h0F, {24'h0, pin_weak_pu});
        bus_stop();

        // Interrupt on input pins only
        ext_low = 8'h10;
        wait_clk(10);
        expect_obs("R6 driven pin ignored", 32'h1, {31'h0, irq_n});
        ext_low = 8'h12;
        wait_clk(10);
        expect_obs("R6 input change asserts", 32'h0, {31'h0, irq_n});
        ext_low = 8'h10;
        wait_clk(10);
        expect_obs("R9 return clears", 32'h1, {31'h0, irq_n});
        ext_low = 8'h02;
        wait_clk(10);
        expect_obs("R6 asserts again", 32'h0, {31'h0, irq_n});

        // Read to another address must not touch the interrupt
        bus_start();
        put_byte({1'b0, STRAP ^ 6'b000001, 1'b1}, ack);
        expect_obs("R10 other addr nack", 32'h0, {31'h0, ack});
        bus_stop();
        wait_clk(10);
        expect_obs("R10 irq kept", 32'h0, {31'h0, irq_n});

        // Single-byte read clears the interrupt
        bus_start();
        put_byte(MY_R, ack);
        expect_obs("R7 read addr ack", 32'h1, {31'h0, ack});
        wait_clk(4);
        expect_obs("R7 irq cleared at addr ack", 32'h1, {31'h0, irq_n});
        get_bits(v);
        expect_obs("R11 read byte", 32'h0D, {24'h0, v});
        put_bit(1'b1, 1'b0, 1'b0);
        bus_stop();

        // Two-byte read with a pin change between bytes
        ext_low = 8'h00;
        wait_clk(10);
        expect_obs("R6 differs from read reference", 32'h0, {31'h0, irq_n});
        bus_start();
        put_byte(MY_R, ack);
        wait_clk(4);
        expect_obs("R7 cleared at addr ack", 32'h1, {31'h0, irq_n});
        get_bits(v);
        expect_obs("R11 first read byte", 32'h0F, {24'h0, v});
        ext_low = 8'h08;
        wait_clk(10);
        expect_obs("R6 change mid read", 32'h0, {31'h0, irq_n});
        put_bit(1'b0, 1'b0, 1'b0);
        wait_clk(4);
        expect_obs("R7 cleared at master ack", 32'h1, {31'h0, irq_n});
        get_bits(v);
        expect_obs("R11 second byte resampled", 32'h07, {24'h0, v});
        put_bit(1'b1, 1'b0, 1'b0);
        bus_stop();
        wait_clk(10);
        expect_obs("R11 released after nack", 32'h0, {31'h0, sda_oe});

        // Write reloads the reference
        ext_low = 8'h04;
        wait_clk(10);
        expect_obs("R6 asserted before write", 32'h0, {31'h0, irq_n});
        bus_start();
        put_byte(MY_W, ack);
        put_byte(8'hFB, ack);
        wait_clk(10);
        expect_obs("R8 write clears", 32'h1, {31'h0, irq_n});
        expect_obs("R8 byte latched", 32'hFB, {24'h0, pin_weak_pu});
        bus_stop();

        // Glitches on both lines during a write byte
        ext_low = 8'h00;
        bus_start();
        put_byte(MY_W, ack);
        for (int i = 7; i >= 0; i--)
            put_bit(v_of(8'h3C, i), (i == 2), (i == 5));
        get_bit(b);
        expect_obs("R12 glitched byte acked", 32'h0, {31'h0, b});
        wait_clk(10);
        expect_obs("R12 glitches rejected", 32'h3C, {24'h0, pin_weak_pu});
        bus_stop();

        wait_clk(5);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic v_of(input logic [7:0] v, input int i);
        return v[i];
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule